// File: doc/BRIEF.md
# Interrupt Aggregator with Per-Source Sensitivity

This block gathers a vector of asynchronous condition inputs into one status register and one interrupt line toward a host. Every input first passes through a two-flop synchronizer. A per-source sensitivity setting then decides what the status bit records:

- **Level:** the bit mirrors the synchronized input.
- **Rising or falling edge:** the bit latches on the chosen transition and holds until software reads the status register.

A per-source mask bit decides whether a set status bit may raise the line.

The line drive has three modes, each producing a pin value and an output enable for an external pad:

- push-pull, active low;
- push-pull, active high;
- open-drain, active low, so several peripherals can share one host input as a wired-OR.

Software programs the mask, sensitivity and mode registers through a simple register port with write strobe, read strobe and address. It reads status back through the same port. Read data is combinational from the address.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status reads 0, the mask reads all ones (every source blocked), the sensitivity register reads 0 and the mode register reads 0. The pin is then driven high with output enable high.
- R2: Address 1 holds the mask (bit i = 1 blocks source i). Address 2 holds sensitivity, two bits per source at bits [2i+1:2i]. Address 3 holds the drive mode in bits [1:0]. Each reads back what was written. A write to address 0 (status) has no effect, and addresses 4 to 7 read 0.
- R3: For a source with sensitivity code 00 or 11 (level), its status bit follows the synchronized input, including returning to 0 without any read.
- R4: For a source with sensitivity code 01 (rising), a 0-to-1 input transition sets its status bit. The bit stays set after the input falls, and a status read (read strobe with address 0) clears it.
- R5: For a source with sensitivity code 10 (falling), a 1-to-0 input transition sets its status bit, with the same hold and clear-on-read behaviour as R4.
- R6: An edge detected in the same cycle as a status read leaves its status bit set after that read.
- R7: A source whose mask bit is 1 never asserts the interrupt line. Its status bit remains readable.
- R8: In mode 00 (push-pull, active low) the output enable is 1, and the pin is 0 when any unmasked status bit is set and 1 otherwise.
- R9: In mode 01 (push-pull, active high) the output enable is 1, and the pin is 1 when any unmasked status bit is set and 0 otherwise.
- R10: In modes 10 and 11 (open-drain) the pin value is always 0, and the output enable is 1 only while any unmasked status bit is set.
- R11: An input change is visible in the status register after exactly three rising clock edges: two synchronizer stages plus the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSRC | Asynchronous condition inputs |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_re_i | input | 1 | Register read strobe (a read of address 0 clears latched edges) |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 2*NSRC | Write data |
| cfg_rdata_o | output | 2*NSRC | Read data for the current address |
| irq_pin_o | output | 1 | Value driven on the interrupt pad |
| irq_oe_o | output | 1 | Output enable for the interrupt pad |

## Verification
The hardest case to reach from the ports is an edge whose detection lands in exactly the cycle that a status read clears the latched bits. Only then would a naive clear-then-set ordering lose the event.

The stimulus handles this in three steps:
1. It first leaves an older latched edge in the bit.
2. It launches a new input edge on a falling clock edge.
3. It counts the two synchronizer stages and raises the read strobe so that the clearing edge and the detection coincide.

The bit must still read set afterwards. A second read then clears it. The three-edge latency is pinned down separately by sampling one cycle before and at the expected cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    SENSE_LEVEL     = 2'b00,
    SENSE_RISE      = 2'b01,
    SENSE_FALL      = 2'b10,
    SENSE_LEVEL_ALT = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    PIN_PP_LOW  = 2'b00,
    PIN_PP_HIGH = 2'b01,
    PIN_OD_LOW  = 2'b10,
    PIN_OD_ALT  = 2'b11
  } pin_mode_e;

  localparam logic [AW-1:0] ADDR_STATUS = 3'd0;
  localparam logic [AW-1:0] ADDR_MASK   = 3'd1;
  localparam logic [AW-1:0] ADDR_SENSE  = 3'd2;
  localparam logic [AW-1:0] ADDR_MODE   = 3'd3;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_status_cell.sv
module irq_status_cell
  import irq_agg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] sense_i,
  input  logic       clr_i,
  output logic       sts_o
);
  logic prev_q, prev_d;
  logic sts_q, sts_d;
  logic is_rise, is_fall, is_edge, hit;

  always_comb begin
    is_rise = (sense_i == SENSE_RISE);
    is_fall = (sense_i == SENSE_FALL);
    is_edge = is_rise | is_fall;
    hit     = (is_rise & lvl_i & ~prev_q) | (is_fall & ~lvl_i & prev_q);
    prev_d  = lvl_i;
    if (is_edge) sts_d = (sts_q & ~clr_i) | hit;  // new edge wins over clear
    else         sts_d = lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      sts_q  <= sts_d;
    end
  end

  assign sts_o = sts_q;

  // R3: level sources track the synchronized input one cycle later
  a_r3_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_edge |=> (sts_q == $past(lvl_i)));
  // R4: a latched edge bit holds while no read clears it
  a_r4_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_edge && sts_q && !clr_i) |=> sts_q);
  // R6: a detected edge is stored even under a clearing read
  a_r6_edge_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_edge && hit) |=> sts_q);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_agg_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int DW  = 2 * NSRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] status_i,
  output logic [NSRC-1:0] mask_o,
  output logic [DW-1:0]   sense_o,
  output pin_mode_e       mode_o,
  output logic [DW-1:0]   rdata_o
);
  logic [NSRC-1:0] mask_q, mask_d;
  logic [DW-1:0]   sense_q, sense_d;
  pin_mode_e       mode_q, mode_d;

  always_comb begin
    mask_d  = mask_q;
    sense_d = sense_q;
    mode_d  = mode_q;
    if (we_i) begin
      if (addr_i == ADDR_MASK)  mask_d  = wdata_i[NSRC-1:0];
      if (addr_i == ADDR_SENSE) sense_d = wdata_i;
      if (addr_i == ADDR_MODE)  mode_d  = pin_mode_e'(wdata_i[1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      sense_q <= '0;
      mode_q  <= PIN_PP_LOW;
    end else begin
      mask_q  <= mask_d;
      sense_q <= sense_d;
      mode_q  <= mode_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STATUS: rdata_o[NSRC-1:0] = status_i;
      ADDR_MASK:   rdata_o[NSRC-1:0] = mask_q;
      ADDR_SENSE:  rdata_o           = sense_q;
      ADDR_MODE:   rdata_o[1:0]      = mode_q;
      default:     rdata_o           = '0;
    endcase
  end

  assign mask_o  = mask_q;
  assign sense_o = sense_q;
  assign mode_o  = mode_q;

  // R2: a mask write takes effect on the next cycle
  a_r2_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_MASK) |=> (mask_q == $past(wdata_i[NSRC-1:0])));
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_agg_pkg::*;
(
  input  logic      active_i,
  input  pin_mode_e mode_i,
  output logic      pin_o,
  output logic      oe_o
);
  always_comb begin
    unique case (mode_i)
      PIN_PP_LOW:  begin pin_o = ~active_i; oe_o = 1'b1;     end
      PIN_PP_HIGH: begin pin_o =  active_i; oe_o = 1'b1;     end
      default:     begin pin_o = 1'b0;      oe_o = active_i; end
    endcase
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NSRC        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = 2 * NSRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            cfg_we_i,
  input  logic            cfg_re_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [DW-1:0]   cfg_wdata_i,
  output logic [DW-1:0]   cfg_rdata_o,
  output logic            irq_pin_o,
  output logic            irq_oe_o
);
  logic            rst_n;
  logic [NSRC-1:0] lvl, status, mask;
  logic [DW-1:0]   sense;
  pin_mode_e       mode;
  logic            clr, active;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i(src_i), .q_o(lvl));

  assign clr = cfg_re_i && (cfg_addr_i == ADDR_STATUS);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_cell
      irq_status_cell u_cell (
        .clk_i(clk_i), .rst_ni(rst_n), .lvl_i(lvl[i]),
        .sense_i(sense[2*i +: 2]), .clr_i(clr), .sts_o(status[i]));
    end
  endgenerate

  irq_cfg_regs #(.NSRC(NSRC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .status_i(status), .mask_o(mask),
    .sense_o(sense), .mode_o(mode), .rdata_o(cfg_rdata_o));

  assign active = |(status & ~mask);

  irq_pin_drive u_drive (
    .active_i(active), .mode_i(mode), .pin_o(irq_pin_o), .oe_o(irq_oe_o));

  // R7: with every set bit masked, no mode shows an asserted line
  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((status & ~mask) == '0) |->
      ((mode == PIN_PP_HIGH) ? !irq_pin_o : (mode == PIN_PP_LOW) ? irq_pin_o : !irq_oe_o));
  // R8: push-pull low keeps the pad driven
  a_r8_pp_driven: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == PIN_PP_LOW) |-> irq_oe_o);
  // R9: active-high mode drives 1 for any unmasked set bit
  a_r9_high_active: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == PIN_PP_HIGH && (status & ~mask) != '0) |-> (irq_pin_o && irq_oe_o));
  // R10: open-drain never drives a 1
  a_r10_od_no_high: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode[1] |-> !irq_pin_o);
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int NSRC = 8;
  localparam int DW   = 2 * NSRC;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src;
  logic            we, re;
  logic [2:0]      addr;
  logic [DW-1:0]   wdata;
  logic [DW-1:0]   rdata;
  logic            pin, oe;
  int              checks = 0;
  int              fails  = 0;
  bit              done   = 1'b0;

  always #5 clk = ~clk;

  irq_aggregator #(.NSRC(NSRC), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .cfg_we_i(we), .cfg_re_i(re),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .irq_pin_o(pin), .irq_oe_o(oe));

  // {src[7:0], clear-after, expected status[7:0], expected pin}
  localparam logic [17:0] VEC [9] = '{
    {8'h00, 1'b0, 8'h00, 1'b1},
    {8'hFF, 1'b1, 8'hDB, 1'b0},
    {8'h00, 1'b0, 8'h24, 1'b0},
    {8'h80, 1'b1, 8'hA4, 1'b0},
    {8'h80, 1'b0, 8'h00, 1'b1},
    {8'h08, 1'b0, 8'h08, 1'b0},
    {8'h00, 1'b0, 8'h00, 1'b1},
    {8'h80, 1'b1, 8'h80, 1'b1},
    {8'h00, 1'b0, 8'h00, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a; re = 1'b0; #1; d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rclr();
    addr = 3'd0; re = 1'b1;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] sv;
    rst_n = 1'b0; src = '0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 pin in reset", pin, 1'b1);
    check("R1 oe in reset", oe, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    peek(3'd0, d); check("R1 status", d, 0);
    peek(3'd1, d); check("R1 mask", d, 16'h00FF);
    peek(3'd2, d); check("R1 sense", d, 0);
    peek(3'd3, d); check("R1 mode", d, 0);

    // R2 register access
    @(negedge clk);
    wr(3'd1, 16'h00A5); peek(3'd1, d); check("R2 mask readback", d, 16'h00A5);
    wr(3'd2, 16'hC3E1); peek(3'd2, d); check("R2 sense readback", d, 16'hC3E1);
    wr(3'd3, 16'h0002); peek(3'd3, d); check("R2 mode readback", d, 16'h0002);
    wr(3'd0, 16'hFFFF); peek(3'd0, d); check("R2 status write ignored", d, 0);
    peek(3'd5, d); check("R2 unused address", d, 0);
    wr(3'd2, 16'h0000); wr(3'd3, 16'h0000); wr(3'd1, 16'h0080);

    // R11 latency on level source 0
    @(negedge clk); src = 8'h01;
    @(negedge clk);
    @(negedge clk); peek(3'd0, d); check("R11 not yet after two edges", d[0], 1'b0);
    @(negedge clk); peek(3'd0, d); check("R11 set after three edges", d[0], 1'b1);
    src = 8'h00; settle();

    // table configuration: source i%3 -> level / rise / fall
    sv = '0;
    for (int i = 0; i < NSRC; i++)
      sv[2*i +: 2] = (i % 3 == 1) ? 2'b01 : (i % 3 == 2) ? 2'b10 : 2'b00;
    wr(3'd2, sv);
    rclr();
    for (int v = 0; v < 9; v++) begin
      src = VEC[v][17:10];
      settle();
      peek(3'd0, d);
      check($sformatf("R3/R4/R5 vector %0d status", v), d, {8'h00, VEC[v][8:1]});
      check($sformatf("R7/R8 vector %0d pin", v), pin, VEC[v][0]);
      if (VEC[v][9]) rclr();
    end

    // R4 hold after input falls, cleared by read
    src = 8'h02; settle(); src = 8'h00; settle();
    peek(3'd0, d); check("R4 held after fall", d, 16'h0002);
    rclr(); peek(3'd0, d); check("R4 cleared by read", d, 16'h0000);

    // R6 edge coinciding with a clearing read
    src = 8'h02; settle(); src = 8'h00; settle();
    src = 8'h02;
    @(negedge clk);
    @(negedge clk); addr = 3'd0; re = 1'b1;
    @(negedge clk); re = 1'b0;
    peek(3'd0, d); check("R6 edge kept across read", d, 16'h0002);
    rclr(); peek(3'd0, d); check("R6 later read clears", d, 16'h0000);
    src = 8'h00; settle(); rclr();

    // output modes with level source 0
    src = 8'h01; settle();
    wr(3'd3, 16'h0001); check("R9 pin high", pin, 1'b1); check("R9 oe", oe, 1'b1);
    wr(3'd3, 16'h0002); check("R10 pin low", pin, 1'b0); check("R10 oe on", oe, 1'b1);
    src = 8'h00; settle();
    check("R10 oe off", oe, 1'b0); check("R10 pin idle", pin, 1'b0);
    wr(3'd3, 16'h0001); check("R9 idle pin", pin, 1'b0);
    src = 8'h01; settle();
    wr(3'd3, 16'h0003); check("R10 alt code oe", oe, 1'b1); check("R10 alt code pin", pin, 1'b0);
    wr(3'd3, 16'h0000); check("R8 pin asserted", pin, 1'b0); check("R8 oe", oe, 1'b1);

    // R7 masking
    wr(3'd1, 16'h00FF);
    check("R7 masked pin", pin, 1'b1);
    peek(3'd0, d); check("R7 status visible", d, 16'h0001);
    src = 8'h00; settle();
    check("R8 deasserted", pin, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule